// File: doc/BRIEF.md
# Multi-Level Priority Thread Scheduler

This block decides which hardware thread a small multithreaded processor runs next. It holds one first-in first-out ready list for each of four fixed priority levels, plus one list for blocked threads. Priority 0 is the most urgent. Levels 0 to 2 carry application threads, and level 3 is kept for the idle thread. Every list is a linked list with head and tail pointers, so each append or removal takes a single cycle, however many threads are queued.

A thread manager sends one command per cycle: enqueue, block, unblock or delete, each naming a thread. The block keeps a registered next-thread choice that always tracks the front of the most urgent non-empty ready list. A time-slice pulse moves that choice into the running-thread register, and the thread it replaces goes back to the tail of its own list. Threads of equal priority therefore take turns. An interrupt line bypasses the slice boundary and starts a reserved service thread at once. The service thread runs for one slice and then retires.

Top module: `prio_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `run_valid` and `next_valid` are 0 and every list is empty.
- R2: Command code 0 (enqueue) takes a thread that is in no list and not running, and appends it at the tail of the list chosen by `cmd_prio` (0 most urgent, 3 idle level). Threads on one level leave in arrival order.
- R3: One cycle after any change to the lists, `next_tid` names the front thread of the most urgent non-empty ready list, and `next_valid` shows whether such a thread exists. The blocked list is never chosen.
- R4: When `slice_end` is high and `next_valid` is 1, `run_tid` takes the value of `next_tid` on that edge, and that thread leaves its list. A running application thread that is displaced goes to the tail of its own priority list.
- R5: A thread that becomes ready in the middle of a slice leaves `run_tid` unchanged, even if it is more urgent. Only `slice_end` or `irq` changes the running thread.
- R6: Command code 1 (block) moves a ready or running thread to the tail of the blocked list. A blocked running thread stops running, and `run_valid` drops. Command code 2 (unblock) moves a blocked thread to the tail of the list for its stored priority.
- R7: Command code 3 (delete) frees a thread from any list, including a position in the middle, and the list stays in order around the gap. Deleting the running thread drops `run_valid`.
- R8: When `irq` is high and the service thread (ID `SVC_TID`) is not running, the service thread is running in the next cycle. A displaced thread goes back to the tail of its own list. At the end of its slice the service thread is freed and is not requeued.
- R9: A command is ignored if it comes with `slice_end` or `irq` high, if its 32-bit thread ID is 16 or more, if it names the service thread, or if the thread is in a state the operation does not apply to.
- R10: A `slice_end` with no ready thread leaves an application thread running. If the service thread is running, it retires and `run_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 enqueue, 1 block, 2 unblock, 3 delete |
| cmd_tid | input | 32 | Thread ID the command acts on |
| cmd_prio | input | 2 | Priority level for enqueue |
| slice_end | input | 1 | Time-slice boundary pulse |
| irq | input | 1 | External interrupt request |
| next_valid | output | 1 | A ready thread is waiting |
| next_tid | output | 32 | Thread that the next slice boundary will dispatch |
| run_valid | output | 1 | A thread is running |
| run_tid | output | 32 | Thread that is running |

## Verification
A broken link pointer or a stale head does not always show at once. It shows when the damaged list drains to the fault, at a slice boundary when `run_tid` takes a wrong thread, or one cycle after a command when `next_tid` points at a thread that was deleted or blocked. The bench therefore rotates threads through many slice boundaries after removals from the middle of lists. A wrong per-thread state shows as a command that is accepted or ignored when it should not be, and the next `next_tid` or `run_tid` makes it visible.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int NUM_THREADS = 16;
    localparam int NUM_PRIO    = 4;
    localparam int NUM_QUEUES  = NUM_PRIO + 1;
    localparam int WAIT_Q      = NUM_PRIO;
    localparam int TID_W       = $clog2(NUM_THREADS);
    localparam int PTR_W       = TID_W + 1;
    localparam int PRIO_W      = $clog2(NUM_PRIO);
    localparam int QSEL_W      = $clog2(NUM_QUEUES);
    localparam int WORD_W      = 32;

    typedef logic [PTR_W-1:0] ptr_t;
    localparam ptr_t NIL = '1;

    typedef enum logic [1:0] {
        OP_ENQ     = 2'd0,
        OP_BLOCK   = 2'd1,
        OP_UNBLOCK = 2'd2,
        OP_DELETE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TS_FREE  = 2'd0,
        TS_READY = 2'd1,
        TS_WAIT  = 2'd2,
        TS_RUN   = 2'd3
    } tstate_e;

    function automatic ptr_t to_ptr(input logic [TID_W-1:0] t);
        return {1'b0, t};
    endfunction

    function automatic logic [TID_W-1:0] ptr_idx(input ptr_t p);
        return p[TID_W-1:0];
    endfunction
endpackage

// File: rtl/sched_lists.sv
module sched_lists
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              un_en,
    input  logic [TID_W-1:0]  un_tid,
    input  logic [QSEL_W-1:0] un_q,
    input  logic              ap_en,
    input  logic [TID_W-1:0]  ap_tid,
    input  logic [QSEL_W-1:0] ap_q,
    output ptr_t              head_cur [NUM_QUEUES],
    output ptr_t              head_new [NUM_QUEUES]
);
    ptr_t head_r [NUM_QUEUES];
    ptr_t tail_r [NUM_QUEUES];
    ptr_t nxt_r  [NUM_THREADS];
    ptr_t prv_r  [NUM_THREADS];

    ptr_t h [NUM_QUEUES];
    ptr_t t [NUM_QUEUES];
    ptr_t n [NUM_THREADS];
    ptr_t p [NUM_THREADS];
    ptr_t pred, succ;

    // Removal first, append second: one cycle can move a thread between lists,
    // or pop a head and push a different thread onto the same list.
    always_comb begin
        h = head_r;
        t = tail_r;
        n = nxt_r;
        p = prv_r;
        pred = NIL;
        succ = NIL;
        if (un_en) begin
            pred = p[un_tid];
            succ = n[un_tid];
            if (pred == NIL) h[un_q] = succ;
            else             n[ptr_idx(pred)] = succ;
            if (succ == NIL) t[un_q] = pred;
            else             p[ptr_idx(succ)] = pred;
            n[un_tid] = NIL;
            p[un_tid] = NIL;
        end
        if (ap_en) begin
            n[ap_tid] = NIL;
            p[ap_tid] = t[ap_q];
            if (t[ap_q] == NIL) h[ap_q] = to_ptr(ap_tid);
            else                n[ptr_idx(t[ap_q])] = to_ptr(ap_tid);
            t[ap_q] = to_ptr(ap_tid);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_QUEUES; i++) begin
                head_r[i] <= NIL;
                tail_r[i] <= NIL;
            end
            for (int i = 0; i < NUM_THREADS; i++) begin
                nxt_r[i] <= NIL;
                prv_r[i] <= NIL;
            end
        end else begin
            head_r <= h;
            tail_r <= t;
            nxt_r  <= n;
            prv_r  <= p;
        end
    end

    assign head_cur = head_r;
    assign head_new = h;

    generate
        for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_pair
            assert_head_tail_pair_R2: assert property (@(posedge clk) disable iff (rst)
                (head_r[g] == NIL) == (tail_r[g] == NIL));
        end
    endgenerate

    assert_unlink_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
        un_en |-> (head_r[un_q] != NIL));
endmodule

// File: rtl/sched_pick.sv
module sched_pick
    import sched_pkg::*;
(
    input  ptr_t              heads [NUM_QUEUES],
    output logic              sel_valid,
    output logic [TID_W-1:0]  sel_tid,
    output logic [PRIO_W-1:0] sel_prio
);
    // Scan from the idle level upward so that the most urgent non-empty list wins.
    always_comb begin
        sel_valid = 1'b0;
        sel_tid   = '0;
        sel_prio  = '0;
        for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (heads[i] != NIL) begin
                sel_valid = 1'b1;
                sel_tid   = ptr_idx(heads[i]);
                sel_prio  = PRIO_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_sched.sv
module prio_sched
    import sched_pkg::*;
#(
    parameter int SVC_TID = NUM_THREADS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_tid,
    input  logic [1:0]        cmd_prio,
    input  logic              slice_end,
    input  logic              irq,
    output logic              next_valid,
    output logic [WORD_W-1:0] next_tid,
    output logic              run_valid,
    output logic [WORD_W-1:0] run_tid
);
    localparam logic [TID_W-1:0] SVC = TID_W'(SVC_TID);

    tstate_e             st     [NUM_THREADS];
    tstate_e             st_d   [NUM_THREADS];
    logic [PRIO_W-1:0]   pri    [NUM_THREADS];
    logic [PRIO_W-1:0]   pri_d  [NUM_THREADS];
    logic                run_v, run_v_d;
    logic [TID_W-1:0]    run_t, run_t_d;
    logic                nxt_v;
    logic [TID_W-1:0]    nxt_t;
    logic [PRIO_W-1:0]   nxt_p;

    logic                un_en, ap_en;
    logic [TID_W-1:0]    un_tid, ap_tid;
    logic [QSEL_W-1:0]   un_q, ap_q;
    ptr_t                head_cur [NUM_QUEUES];
    ptr_t                head_new [NUM_QUEUES];
    logic                sel_valid;
    logic [TID_W-1:0]    sel_tid;
    logic [PRIO_W-1:0]   sel_prio;

    logic                tid_ok, svc_running;
    logic [TID_W-1:0]    ct;

    assign ct          = cmd_tid[TID_W-1:0];
    assign tid_ok      = (cmd_tid < WORD_W'(NUM_THREADS)) && (ct != SVC);
    assign svc_running = run_v && (run_t == SVC);

    sched_lists u_lists (
        .clk      (clk),
        .rst      (rst),
        .un_en    (un_en),
        .un_tid   (un_tid),
        .un_q     (un_q),
        .ap_en    (ap_en),
        .ap_tid   (ap_tid),
        .ap_q     (ap_q),
        .head_cur (head_cur),
        .head_new (head_new)
    );

    sched_pick u_pick (
        .heads    (head_new),
        .sel_valid(sel_valid),
        .sel_tid  (sel_tid),
        .sel_prio (sel_prio)
    );

    // Event decode: interrupt over slice boundary over command.
    always_comb begin
        st_d    = st;
        pri_d   = pri;
        run_v_d = run_v;
        run_t_d = run_t;
        un_en   = 1'b0;
        un_tid  = '0;
        un_q    = '0;
        ap_en   = 1'b0;
        ap_tid  = '0;
        ap_q    = '0;
        if (irq) begin
            if (!svc_running) begin
                if (run_v) begin
                    ap_en        = 1'b1;
                    ap_tid       = run_t;
                    ap_q         = QSEL_W'(pri[run_t]);
                    st_d[run_t]  = TS_READY;
                end
                run_v_d    = 1'b1;
                run_t_d    = SVC;
                st_d[SVC]  = TS_RUN;
                pri_d[SVC] = '0;
            end
        end else if (slice_end) begin
            if (nxt_v) begin
                un_en  = 1'b1;
                un_tid = nxt_t;
                un_q   = QSEL_W'(nxt_p);
                if (svc_running) begin
                    st_d[run_t] = TS_FREE;
                end else if (run_v) begin
                    ap_en       = 1'b1;
                    ap_tid      = run_t;
                    ap_q        = QSEL_W'(pri[run_t]);
                    st_d[run_t] = TS_READY;
                end
                run_v_d     = 1'b1;
                run_t_d     = nxt_t;
                st_d[nxt_t] = TS_RUN;
            end else if (svc_running) begin
                run_v_d   = 1'b0;
                st_d[SVC] = TS_FREE;
            end
        end else if (cmd_valid && tid_ok) begin
            unique case (op_e'(cmd_op))
                OP_ENQ: begin
                    if (st[ct] == TS_FREE) begin
                        ap_en     = 1'b1;
                        ap_tid    = ct;
                        ap_q      = QSEL_W'(cmd_prio);
                        pri_d[ct] = PRIO_W'(cmd_prio);
                        st_d[ct]  = TS_READY;
                    end
                end
                OP_BLOCK: begin
                    if (st[ct] == TS_READY) begin
                        un_en    = 1'b1;
                        un_tid   = ct;
                        un_q     = QSEL_W'(pri[ct]);
                        ap_en    = 1'b1;
                        ap_tid   = ct;
                        ap_q     = QSEL_W'(WAIT_Q);
                        st_d[ct] = TS_WAIT;
                    end else if (st[ct] == TS_RUN) begin
                        ap_en    = 1'b1;
                        ap_tid   = ct;
                        ap_q     = QSEL_W'(WAIT_Q);
                        run_v_d  = 1'b0;
                        st_d[ct] = TS_WAIT;
                    end
                end
                OP_UNBLOCK: begin
                    if (st[ct] == TS_WAIT) begin
                        un_en    = 1'b1;
                        un_tid   = ct;
                        un_q     = QSEL_W'(WAIT_Q);
                        ap_en    = 1'b1;
                        ap_tid   = ct;
                        ap_q     = QSEL_W'(pri[ct]);
                        st_d[ct] = TS_READY;
                    end
                end
                OP_DELETE: begin
                    if (st[ct] == TS_READY || st[ct] == TS_WAIT) begin
                        un_en    = 1'b1;
                        un_tid   = ct;
                        un_q     = (st[ct] == TS_WAIT) ? QSEL_W'(WAIT_Q) : QSEL_W'(pri[ct]);
                        st_d[ct] = TS_FREE;
                    end else if (st[ct] == TS_RUN) begin
                        run_v_d  = 1'b0;
                        st_d[ct] = TS_FREE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                st[i]  <= TS_FREE;
                pri[i] <= '0;
            end
            run_v <= 1'b0;
            run_t <= '0;
            nxt_v <= 1'b0;
            nxt_t <= '0;
            nxt_p <= '0;
        end else begin
            st    <= st_d;
            pri   <= pri_d;
            run_v <= run_v_d;
            run_t <= run_t_d;
            nxt_v <= sel_valid;
            nxt_t <= sel_tid;
            nxt_p <= sel_prio;
        end
    end

    assign next_valid = nxt_v;
    assign next_tid   = WORD_W'(nxt_t);
    assign run_valid  = run_v;
    assign run_tid    = WORD_W'(run_t);

    logic any_ready_q;
    always_comb begin
        any_ready_q = 1'b0;
        for (int i = 0; i < NUM_PRIO; i++) begin
            if (head_cur[i] != NIL) any_ready_q = 1'b1;
        end
    end

    assert_next_tracks_lists_R3: assert property (@(posedge clk) disable iff (rst)
        next_valid == any_ready_q);

    assert_slice_load_R4: assert property (@(posedge clk) disable iff (rst)
        (slice_end && !irq && next_valid) |=> (run_valid && run_tid == $past(next_tid)));

    assert_run_held_midslice_R5: assert property (@(posedge clk) disable iff (rst)
        (!slice_end && !irq) |=> (!run_valid || ($past(run_valid) && run_tid == $past(run_tid))));

    assert_irq_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !(run_valid && run_tid == WORD_W'(SVC_TID))) |=> (run_valid && run_tid == WORD_W'(SVC_TID)));
endmodule

// File: tb/test_prio_sched.sv
module test_prio_sched;
    localparam int CLK_P = 10;
    localparam int NT    = 16;
    localparam int SVC   = 15;
    localparam int S_FREE = 0, S_RDY = 1, S_WAIT = 2, S_RUN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_tid = '0;
    logic [1:0]  cmd_prio = '0;
    logic        slice_end = 1'b0;
    logic        irq = 1'b0;
    logic        next_valid, run_valid;
    logic [31:0] next_tid, run_tid;

    int checks = 0;
    int errors = 0;

    int mq [5][$];
    int mst [NT];
    int mpri [NT];
    bit mrv;
    int mrt;

    always #(CLK_P/2) clk = ~clk;

    prio_sched i_prio_sched (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tid(cmd_tid), .cmd_prio(cmd_prio), .slice_end(slice_end), .irq(irq),
        .next_valid(next_valid), .next_tid(next_tid),
        .run_valid(run_valid), .run_tid(run_tid)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        summary();
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_next(output bit v, output int t);
        v = 0;
        t = 0;
        for (int q = 0; q < 4; q++) begin
            if (!v && mq[q].size() > 0) begin
                v = 1;
                t = mq[q][0];
            end
        end
    endfunction

    function automatic void qdel(int q, int t);
        for (int i = 0; i < mq[q].size(); i++) begin
            if (mq[q][i] == t) begin
                mq[q].delete(i);
                return;
            end
        end
    endfunction

    function automatic void model_reset();
        for (int q = 0; q < 5; q++) mq[q].delete();
        for (int i = 0; i < NT; i++) begin
            mst[i] = S_FREE;
            mpri[i] = 0;
        end
        mrv = 0;
        mrt = 0;
    endfunction

    function automatic void model_apply(bit cv, int op, logic [31:0] tid, int pr, bit se, bit ir);
        bit nv;
        int nt, t;
        model_next(nv, nt);
        if (ir) begin
            if (!(mrv && mrt == SVC)) begin
                if (mrv) begin
                    mq[mpri[mrt]].push_back(mrt);
                    mst[mrt] = S_RDY;
                end
                mrv = 1;
                mrt = SVC;
                mst[SVC] = S_RUN;
                mpri[SVC] = 0;
            end
        end else if (se) begin
            if (nv) begin
                void'(mq[mpri[nt]].pop_front());
                if (mrv && mrt == SVC) mst[SVC] = S_FREE;
                else if (mrv) begin
                    mq[mpri[mrt]].push_back(mrt);
                    mst[mrt] = S_RDY;
                end
                mrv = 1;
                mrt = nt;
                mst[nt] = S_RUN;
            end else if (mrv && mrt == SVC) begin
                mrv = 0;
                mst[SVC] = S_FREE;
            end
        end else if (cv && tid < NT && tid != SVC) begin
            t = int'(tid);
            case (op)
                0: if (mst[t] == S_FREE) begin
                       mpri[t] = pr;
                       mq[pr].push_back(t);
                       mst[t] = S_RDY;
                   end
                1: if (mst[t] == S_RDY) begin
                       qdel(mpri[t], t);
                       mq[4].push_back(t);
                       mst[t] = S_WAIT;
                   end else if (mst[t] == S_RUN) begin
                       mq[4].push_back(t);
                       mrv = 0;
                       mst[t] = S_WAIT;
                   end
                2: if (mst[t] == S_WAIT) begin
                       qdel(4, t);
                       mq[mpri[t]].push_back(t);
                       mst[t] = S_RDY;
                   end
                default: if (mst[t] == S_RDY) begin
                       qdel(mpri[t], t);
                       mst[t] = S_FREE;
                   end else if (mst[t] == S_WAIT) begin
                       qdel(4, t);
                       mst[t] = S_FREE;
                   end else if (mst[t] == S_RUN) begin
                       mrv = 0;
                       mst[t] = S_FREE;
                   end
            endcase
        end
    endfunction

    task automatic compare(string tag);
        bit ev;
        int et;
        model_next(ev, et);
        check(tag, "next_valid", int'(next_valid), int'(ev));
        if (ev) check(tag, "next_tid", int'(next_tid), et);
        check(tag, "run_valid", int'(run_valid), int'(mrv));
        if (mrv) check(tag, "run_tid", int'(run_tid), mrt);
    endtask

    task automatic cyc(string tag, bit cv, int op, logic [31:0] tid, int pr, bit se, bit ir);
        cmd_valid = cv;
        cmd_op = 2'(op);
        cmd_tid = tid;
        cmd_prio = 2'(pr);
        slice_end = se;
        irq = ir;
        model_apply(cv, op, tid, pr, se, ir);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic cmd(string tag, int op, logic [31:0] tid, int pr);
        cyc(tag, 1, op, tid, pr, 0, 0);
    endtask

    task automatic slice(string tag);
        cyc(tag, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        bit cv, se, ir;
        int op, pr, r;
        logic [31:0] tid;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", "next_valid in reset", int'(next_valid), 0);
        check("R1", "run_valid in reset", int'(run_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        compare("R1");

        // R2: same-level FIFO order and the idle level
        cmd("R2", 0, 4, 2);
        cmd("R2", 0, 6, 2);
        cmd("R2", 0, 8, 2);
        cmd("R2", 0, 1, 3);
        cmd("R9", 0, 4, 0);            // already queued: ignored
        // R4: round-robin rotation across slice boundaries
        repeat (5) slice("R4");
        // R5: urgent arrival mid-slice waits for the boundary
        cmd("R5", 0, 2, 0);
        cyc("R5", 0, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 0);
        slice("R3");
        slice("R4");
        // R6 and R7: removal from the middle of a list, then restore
        cmd("R6", 0, 9, 1);
        cmd("R6", 0, 10, 1);
        cmd("R6", 0, 11, 1);
        cmd("R7", 1, 10, 0);
        repeat (3) slice("R7");
        cmd("R6", 2, 10, 0);
        cmd("R9", 2, 9, 0);            // not blocked: ignored
        repeat (3) slice("R6");
        cmd("R7", 3, 6, 0);
        cmd("R7", 3, 10, 0);
        slice("R7");
        cmd("R6", 1, run_tid, 0);      // block the running thread
        cmd("R7", 3, 11, 0);
        slice("R4");
        cmd("R7", 3, run_tid, 0);      // delete the running thread
        // R8: interrupt dispatch and service retirement
        slice("R4");
        cyc("R8", 0, 0, 0, 0, 0, 1);
        cyc("R8", 0, 0, 0, 0, 0, 1);   // service already running
        cmd("R9", 3, SVC, 0);
        slice("R8");
        // R9: out-of-range IDs and commands colliding with events
        cmd("R9", 0, 16, 0);
        cmd("R9", 0, 32'h0001_0003, 0);
        cyc("R9", 1, 0, 12, 0, 1, 0);
        cyc("R9", 1, 0, 13, 0, 0, 1);
        slice("R8");
        // R10: drain everything, then boundaries with nothing ready
        for (int i = 0; i < NT; i++) cmd("R10", 3, i, 0);
        cmd("R10", 0, 5, 1);
        slice("R10");
        slice("R10");
        cyc("R10", 0, 0, 0, 0, 0, 1);
        slice("R10");

        // random phase, all requirements against the model
        for (int k = 0; k < 4000; k++) begin
            cv  = ($urandom % 4) != 0;
            op  = $urandom % 4;
            pr  = $urandom % 4;
            r   = $urandom % 20;
            tid = (r == 0) ? 32'hFFFF_FFF2 : 32'($urandom % 18);
            se  = ($urandom % 6) == 0;
            ir  = ($urandom % 50) == 0;
            cyc("R3", cv, op, tid, pr, se, ir);
        end
        summary();
    end
endmodule